// File: doc/BRIEF.md
# Pre/Post-Trigger Logic Capture Engine

This block is the acquisition core of a small logic analyzer. Every input channel owns two registers of equal length. The first is a collection shift register that takes one new bit from its channel on each enabled sample clock. The second is a display register that keeps a frozen snapshot. A transition of the selected polarity on the trigger line starts a programmable post-trigger countdown, and collection keeps running while the countdown lasts. When the countdown ends, collection stops and every collection register is copied into its display register in a single clock. The frozen window therefore holds the samples taken after the trigger and, above them, the samples taken at or before it. The trigger's index within the window is reported as a number, so that a cursor can be drawn on it.

Software or a sequencer writes the post-trigger delay and the slope and then pulses the arm/clear input. It waits for the done pulse or polls the sticky done flag, and then reads the display contents and the trigger index. The display stays unchanged until a later capture completes.

Top module: `logic_capture_engine`

## Requirements
- R1: While the engine is collecting, every clock with `samp_en` high shifts each channel's input bit into bit 0 of that channel's collection register, and older bits move one place toward index DEPTH-1. Channel c occupies bits [c*DEPTH +: DEPTH] of `view_data`.
- R2: With `trig_fall` = 0 a low-to-high change of `trig_in` is a trigger, and with `trig_fall` = 1 a high-to-low change is. `trig_in` passes through two synchronizing flops, so a level applied before clock edge n is acted on at edge n+2, which is the trigger clock.
- R3: After the trigger clock, collection continues for D further enabled sample clocks, where D is the effective delay. The display is loaded on the next clock after that. Window index 0 is therefore the newest post-trigger sample, indices 0..D-1 hold post-trigger samples, and indices D..DEPTH-1 hold samples taken at or before the trigger clock.
- R4: A `post_dly` value of DEPTH or more is clamped to DEPTH-1, so at least one sample from at or before the trigger remains in the window.
- R5: `trig_pos` gives the effective delay D, latched at the trigger clock, and stays constant while a capture is complete.
- R6: The display registers change only on the load clock. At all other times they hold their contents, including across arm/clear.
- R7: `done_pulse` is high for exactly one clock, the cycle right after the load edge. `done_flag` rises in the same cycle and stays high until arm/clear.
- R8: Trigger edges that arrive during the countdown or after the capture has completed have no effect. The window, `trig_pos` and the done outputs do not change, and no second `done_pulse` occurs.
- R9: A clock with `arm_clr` high clears `done_flag` for the next cycle, performs no shift, ignores any trigger and returns the engine to collecting.
- R10: After reset, `done_pulse`, `done_flag`, `trig_pos` and all display bits are 0, and the engine is collecting.
- R11: A clock with `samp_en` low neither shifts the collection registers nor advances the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Sample enable for the current clock |
| ch_in | input | NUM_CH | One input bit per channel |
| trig_in | input | 1 | Asynchronous trigger line |
| trig_fall | input | 1 | Trigger slope: 0 = rising, 1 = falling |
| post_dly | input | DLY_W | Requested post-trigger sample count |
| arm_clr | input | 1 | Clears done status and restarts collection |
| done_pulse | output | 1 | One-clock pulse after the display is loaded |
| done_flag | output | 1 | Sticky capture-complete status |
| view_data | output | NUM_CH*DEPTH | Display registers, channel c at [c*DEPTH +: DEPTH] |
| trig_pos | output | $clog2(DEPTH) | Window index of the trigger sample |

## Verification
A reduced configuration is swept over every requested delay from zero to twice the register length, over both trigger slopes and over two enable patterns. Sweeping the delays separates correct pre/post splitting from off-by-one errors in the countdown, and the values above the length exercise the clamp. One enable pattern keeps `samp_en` high on every clock, while the other drops it on every third clock. The second pattern shows whether gaps in the sample stream are skipped by both the shift and the count. Extra trigger edges injected during the countdown and after completion show whether late triggers are really ignored, and the cycle-exact timing of `done_pulse` is compared with an arithmetic prediction on every clock of every run.

// File: rtl/lce_pkg.sv
package lce_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_POST    = 2'd1,
        ST_DONE    = 2'd2
    } cap_state_e;

endpackage

// File: rtl/lce_trig_detect.sv
module lce_trig_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic trig_fall,
    output logic edge_hit
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = trig_in;
        r_d.s2   = r_q.s1;
        r_d.prev = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Slope compare between the settled sample and the one before it
    assign edge_hit = trig_fall ? (r_q.prev & ~r_q.s2) : (r_q.s2 & ~r_q.prev);

endmodule

// File: rtl/lce_chan_pair.sv
module lce_chan_pair #(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             shift_en,
    input  logic             load_en,
    output logic [DEPTH-1:0] disp_out
);

    typedef struct packed {
        logic [DEPTH-1:0] coll;
        logic [DEPTH-1:0] disp;
    } pair_t;

    pair_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (shift_en) begin
            r_d.coll = {r_q.coll[DEPTH-2:0], bit_in};
        end
        if (load_en) begin
            r_d.disp = r_q.coll;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign disp_out = r_q.disp;

endmodule

// File: rtl/lce_ctrl.sv
module lce_ctrl
    import lce_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DLY_W = 5,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic             edge_hit,
    input  logic             arm_clr,
    input  logic [DLY_W-1:0] post_dly,
    output logic             shift_en,
    output logic             load_en,
    output logic             done_pulse,
    output logic             done_flag,
    output logic [IDX_W-1:0] trig_pos
);

    localparam logic [DLY_W-1:0] MAX_DLY = DLY_W'(DEPTH - 1);
    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        cap_state_e       state;
        logic [IDX_W-1:0] cnt;
        logic [IDX_W-1:0] pos;
        logic             pulse;
        logic             flag;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic [IDX_W-1:0] dly_eff;

    always_comb begin
        dly_eff = (post_dly > MAX_DLY) ? MAX_IDX : post_dly[IDX_W-1:0];
    end

    always_comb begin
        r_d      = r_q;
        r_d.pulse = 1'b0;
        shift_en = 1'b0;
        load_en  = 1'b0;
        if (arm_clr) begin
            r_d.state = ST_COLLECT;
            r_d.flag  = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_COLLECT: begin
                    shift_en = samp_en;
                    if (edge_hit) begin
                        r_d.state = ST_POST;
                        r_d.cnt   = dly_eff;
                        r_d.pos   = dly_eff;
                    end
                end
                ST_POST: begin
                    if (r_q.cnt == '0) begin
                        load_en   = 1'b1;
                        r_d.state = ST_DONE;
                        r_d.pulse = 1'b1;
                        r_d.flag  = 1'b1;
                    end else if (samp_en) begin
                        shift_en = 1'b1;
                        r_d.cnt  = r_q.cnt - IDX_W'(1);
                    end
                end
                default: begin
                    r_d.state = ST_DONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_COLLECT;
            r_q.cnt   <= '0;
            r_q.pos   <= '0;
            r_q.pulse <= 1'b0;
            r_q.flag  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_pulse = r_q.pulse;
    assign done_flag  = r_q.flag;
    assign trig_pos   = r_q.pos;

endmodule

// File: rtl/logic_capture_engine.sv
module logic_capture_engine #(
    parameter int NUM_CH = 20,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int DLY_W  = IDX_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    samp_en,
    input  logic [NUM_CH-1:0]       ch_in,
    input  logic                    trig_in,
    input  logic                    trig_fall,
    input  logic [DLY_W-1:0]        post_dly,
    input  logic                    arm_clr,
    output logic                    done_pulse,
    output logic                    done_flag,
    output logic [NUM_CH*DEPTH-1:0] view_data,
    output logic [IDX_W-1:0]        trig_pos
);

    logic edge_hit;
    logic shift_en;
    logic load_en;

    lce_trig_detect u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_fall (trig_fall),
        .edge_hit  (edge_hit)
    );

    lce_ctrl #(
        .DEPTH (DEPTH),
        .DLY_W (DLY_W),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_en    (samp_en),
        .edge_hit   (edge_hit),
        .arm_clr    (arm_clr),
        .post_dly   (post_dly),
        .shift_en   (shift_en),
        .load_en    (load_en),
        .done_pulse (done_pulse),
        .done_flag  (done_flag),
        .trig_pos   (trig_pos)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        lce_chan_pair #(
            .DEPTH (DEPTH)
        ) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .bit_in   (ch_in[c]),
            .shift_en (shift_en),
            .load_en  (load_en),
            .disp_out (view_data[c*DEPTH +: DEPTH])
        );
    end

endmodule

// File: rtl/lce_checker.sv
module lce_checker #(
    parameter int NUM_CH = 20,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    samp_en,
    input logic                    arm_clr,
    input logic                    shift_en,
    input logic                    load_en,
    input logic                    done_pulse,
    input logic                    done_flag,
    input logic [NUM_CH*DEPTH-1:0] view_data,
    input logic [IDX_W-1:0]        trig_pos
);

    a_r11_no_shift_without_en: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |-> !shift_en);

    a_r6_display_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(view_data));

    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    a_r7_pulse_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(load_en));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !arm_clr) |=> done_flag);

    a_r9_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm_clr |=> !done_flag);

    a_r8_frozen_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag |-> !shift_en && !load_en);

    a_r5_pos_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !arm_clr) |=> $stable(trig_pos));

endmodule

bind logic_capture_engine lce_checker #(
    .NUM_CH (NUM_CH),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W)
) u_lce_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_en    (samp_en),
    .arm_clr    (arm_clr),
    .shift_en   (shift_en),
    .load_en    (load_en),
    .done_pulse (done_pulse),
    .done_flag  (done_flag),
    .view_data  (view_data),
    .trig_pos   (trig_pos)
);

// File: tb/logic_capture_engine_tb_top.sv
`timescale 1ns/1ps
module logic_capture_engine_tb_top;

    localparam int NC = 3;
    localparam int DP = 8;
    localparam int IW = 3;
    localparam int DW = 4;
    localparam int T0 = 2*DP + 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              samp_en;
    logic [NC-1:0]     ch_in;
    logic              trig_in;
    logic              trig_fall;
    logic [DW-1:0]     post_dly;
    logic              arm_clr;
    logic              done_pulse;
    logic              done_flag;
    logic [NC*DP-1:0]  view_data;
    logic [IW-1:0]     trig_pos;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    logic_capture_engine #(
        .NUM_CH (NC),
        .DEPTH  (DP),
        .IDX_W  (IW),
        .DLY_W  (DW)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_en    (samp_en),
        .ch_in      (ch_in),
        .trig_in    (trig_in),
        .trig_fall  (trig_fall),
        .post_dly   (post_dly),
        .arm_clr    (arm_clr),
        .done_pulse (done_pulse),
        .done_flag  (done_flag),
        .view_data  (view_data),
        .trig_pos   (trig_pos)
    );

    function automatic logic pat(int k, int c);
        return logic'((((k * 5) + (c * 3)) ^ (k >> 1) ^ (k >> 3)) & 1);
    endfunction

    function automatic logic en_of(int mode, int k);
        return (mode == 0) ? 1'b1 : ((k % 3) != 1);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic run_capture(int d, bit fall, int mode);
        int de;
        int tpos;
        int newest;
        int loadp;
        int cnt;
        int idx;
        logic [NC*DP-1:0] exp_v;
        logic act_lvl;
        logic lvl;
        de   = (d > DP - 1) ? DP - 1 : d;   // R4 clamp
        tpos = T0 + 2;                      // R2 two-flop latency
        newest = -1;
        for (int j = tpos; j >= 0; j--) begin
            if (en_of(mode, j)) begin newest = j; break; end
        end
        cnt = de;
        loadp = -1;
        for (int j = tpos + 1; j < tpos + 64; j++) begin
            if (cnt == 0) begin loadp = j; break; end
            if (en_of(mode, j)) begin newest = j; cnt--; end   // R11
        end
        exp_v = '0;
        for (int c = 0; c < NC; c++) begin
            idx = 0;
            for (int j = newest; j >= 1; j--) begin
                if (en_of(mode, j) && idx < DP) begin
                    exp_v[c*DP + idx] = pat(j, c);
                    idx++;
                end
            end
        end
        act_lvl = ~fall;
        trig_fall = fall;
        post_dly  = DW'(d);
        for (int k = 0; k <= loadp + 8; k++) begin
            @(negedge clk);
            if (k == 1)
                check(done_flag == 1'b0, "R9", "flag after arm", done_flag, 0);
            if (k >= 1)
                check(done_pulse == ((k - 1) == loadp), "R7", "done_pulse timing",
                      done_pulse, ((k - 1) == loadp));
            if ((k - 1) == loadp) begin
                check(view_data == exp_v, "R3", "captured window", view_data, exp_v);
                check(trig_pos == IW'(de), "R5", "trigger index", trig_pos, de);
                check(done_flag == 1'b1, "R7", "flag set", done_flag, 1);
            end
            arm_clr = (k == 0);
            samp_en = en_of(mode, k);
            for (int c = 0; c < NC; c++) ch_in[c] = pat(k, c);
            lvl = (k >= T0) ? act_lvl : ~act_lvl;
            if (de >= 4 && (k == T0 + 1 || k == T0 + 2)) lvl = ~act_lvl;   // R8 edge in countdown
            if (k >= loadp + 2 && k < loadp + 4) lvl = ~act_lvl;            // R8 edge after done
            trig_in = lvl;
        end
        @(negedge clk);
        check(view_data == exp_v, "R8", "window after late edges", view_data, exp_v);
        check(done_flag == 1'b1, "R7", "flag sticky", done_flag, 1);
        check(trig_pos == IW'(de), "R8", "index after late edges", trig_pos, de);
        check(done_pulse == 1'b0, "R8", "no second pulse", done_pulse, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        samp_en   = 1'b0;
        ch_in     = '0;
        trig_in   = 1'b0;
        trig_fall = 1'b0;
        post_dly  = '0;
        arm_clr   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_pulse == 1'b0, "R10", "reset pulse", done_pulse, 0);
        check(done_flag == 1'b0, "R10", "reset flag", done_flag, 0);
        check(view_data == '0, "R10", "reset display", view_data, 0);
        check(trig_pos == '0, "R10", "reset index", trig_pos, 0);
        for (int mode = 0; mode < 2; mode++)
            for (int f = 0; f < 2; f++)
                for (int d = 0; d < 16; d++)
                    run_capture(d, f[0], mode);   // R1 R2 R3 R4 R6 R11 swept
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule